// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast input clock by a programmable ratio N = M·P + A. A prescaler, modelled here in logic, counts input cycles in groups of either P or P+1. Two down-counters sit behind it. The main counter is loaded with M and steps once per prescaler cycle. The swallow counter is loaded with A and steers the prescaler's modulus line.

In each output period the prescaler first runs A groups of P+1 input cycles. It then runs M−A groups of P cycles. The sum is exactly M·P + A input cycles. When the main counter finishes a period, three things happen on the same input clock edge:

- both counters reload from the programmed values;
- the modulus line returns to P+1;
- a one-cycle output pulse is raised.

Values written mid-period therefore never disturb the period already running. The block also flags settings that do not meet its rules. It repairs them as follows: a zero M is treated as 1, and A is clamped to M.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high on a clock edge, the prescaler phase restarts, both counters load from the inputs, and `divPulse` is 0 after that edge.
- R2: After reset or after a pulse, the next `divPulse` rises exactly N input edges later. N = Me·P + Ae, where Me = max(M,1) and Ae = min(A,Me), sampled at the loading edge.
- R3: Counting edges from the start of a period, `modCtl` is 1 for the first Ae·(P+1) cycles of that period and 0 for the rest.
- R4: `divPulse` is high for exactly one input cycle per period and is 0 in every other cycle.
- R5: Changes to `mIn` and `aIn` during a period do not change the length of that period. They take effect only from the next reload edge.
- R6: When A > M, the division uses A = M, giving N = M·(P+1).
- R7: When M = 0, the division uses M = 1, giving N = P + min(A,1).
- R8: `cfgErr` is 1 exactly when M = 0, A > M, or A > P. It is combinational from the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| mIn | input | M_W | Programmed main count M |
| aIn | input | A_W | Programmed swallow count A |
| divPulse | output | 1 | One-cycle pulse per divided period |
| modCtl | output | 1 | Prescaler modulus select: 1 selects P+1, 0 selects P |
| cfgErr | output | 1 | Programmed values break M≥1, M≥A or A≤P |

## Verification
A wrong prescaler phase or main count shows up as a pulse that comes one or more input cycles early or late. The bench catches this in the period where it first happens, because every edge is compared against a running edge count. A swallow counter that fails to stop at zero, or that reloads wrongly, makes `modCtl` differ from the expected profile within one prescaler group. Loading new values at the wrong moment changes the length of the period in which they were written, so the next pulse falls on the wrong edge.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;
  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic load;   // reload both counters (reset or end of period)
    logic step;   // a prescaler group ended and the period goes on
    logic wrap;   // a prescaler group ended the whole period
  } divStrobe_t;
endpackage

// File: rtl/swallow_divider_ctrl.sv
module swallow_divider_ctrl
  import swallow_divider_pkg::*;
#(
  parameter int P = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       swNonZero,
  input  logic       mainOne,
  output divStrobe_t strobe
);
  localparam int PC_W = $clog2(P + 1);

  logic [PC_W-1:0] preCnt;
  logic            preEnd;

  // A group lasts P+1 cycles while the swallow count is nonzero, otherwise P
  assign preEnd = swNonZero ? (preCnt == PC_W'(P)) : (preCnt == PC_W'(P - 1));

  always_ff @(posedge clk) begin
    if (rst || preEnd) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.wrap = !rst && preEnd && mainOne;
    strobe.step = !rst && preEnd && !mainOne;
    strobe.load = rst || strobe.wrap;
  end

  // R3: the prescaler phase never passes the longer modulus
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PC_W'(P));

  // R3: after a group of P cycles with swallow done, phase restarts
  a_r3_short_group: assert property (@(posedge clk) disable iff (rst)
    (!swNonZero && preCnt == PC_W'(P - 1)) |=> (preCnt == '0));
endmodule

// File: rtl/swallow_divider_dp.sv
module swallow_divider_dp
  import swallow_divider_pkg::*;
#(
  parameter int P   = 8,
  parameter int M_W = 10,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] mIn,
  input  logic [A_W-1:0] aIn,
  input  divStrobe_t     strobe,
  output logic           swNonZero,
  output logic           mainOne,
  output logic           divPulse,
  output logic           cfgErr
);
  logic [M_W-1:0] mainCnt;
  logic [A_W-1:0] swCnt;
  logic [M_W-1:0] mEff;
  logic [M_W-1:0] aExt;
  logic [A_W-1:0] aEff;

  // Repair of the programmed values (R6, R7)
  always_comb begin
    mEff = (mIn == '0) ? M_W'(1) : mIn;
    aExt = M_W'(aIn);
    aEff = (aExt > mEff) ? mEff[A_W-1:0] : aIn;
  end

  // R8: flag of the programmed values
  assign cfgErr = (mIn == '0) || (aExt > mIn) || (int'(aIn) > P);

  assign swNonZero = (swCnt != '0);
  assign mainOne   = (mainCnt == M_W'(1));

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      mainCnt <= mEff;
      swCnt   <= aEff;
    end else if (strobe.step) begin
      mainCnt <= mainCnt - 1'b1;
      if (swNonZero) swCnt <= swCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divPulse <= 1'b0;
    else     divPulse <= strobe.wrap;
  end

  // R4: the output pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R6: the swallow count never exceeds the main count
  a_r6_sw_le_main: assert property (@(posedge clk) disable iff (rst)
    M_W'(swCnt) <= mainCnt);

  // R2: the main counter never reaches zero
  a_r2_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    mainCnt != '0);

  // R5: without a strobe, the counters hold
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> ($stable(mainCnt) && $stable(swCnt)));

  // R3: once the swallow count is zero it stays there until a reload
  a_r3_sw_sticky: assert property (@(posedge clk) disable iff (rst)
    (!swNonZero && !strobe.load) |=> !swNonZero);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_divider_pkg::*;
#(
  parameter int P   = 8,
  parameter int M_W = 10,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] mIn,
  input  logic [A_W-1:0] aIn,
  output logic           divPulse,
  output logic           modCtl,
  output logic           cfgErr
);
  divStrobe_t strobe;
  logic       swNonZero;
  logic       mainOne;

  swallow_divider_ctrl #(.P(P)) u_ctrl (
    .clk(clk), .rst(rst), .swNonZero(swNonZero), .mainOne(mainOne), .strobe(strobe)
  );

  swallow_divider_dp #(.P(P), .M_W(M_W), .A_W(A_W)) u_dp (
    .clk(clk), .rst(rst), .mIn(mIn), .aIn(aIn), .strobe(strobe),
    .swNonZero(swNonZero), .mainOne(mainOne), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  assign modCtl = swNonZero;

  // R1: no output pulse right after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !divPulse);
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int P   = 8;
  localparam int M_W = 10;
  localparam int A_W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [M_W-1:0] mIn = 10'd3;
  logic [A_W-1:0] aIn = 4'd1;
  logic           divPulse, modCtl, cfgErr;

  int errors = 0;
  int checks = 0;
  int cnt    = 0;   // edges done in the current period
  int curN   = 0;   // expected length of the current period
  int curAe  = 0;   // clamped swallow count of the current period
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  swallow_divider #(.P(P), .M_W(M_W), .A_W(A_W)) u_swallow_divider (
    .clk(clk), .rst(rst), .mIn(mIn), .aIn(aIn),
    .divPulse(divPulse), .modCtl(modCtl), .cfgErr(cfgErr)
  );

  function automatic int effM(int m);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic int effA(int m, int a);
    return (a > effM(m)) ? effM(m) : a;
  endfunction

  function automatic int ratio(int m, int a);
    return effM(m) * P + effA(m, a);
  endfunction

  function automatic bit expErr(int m, int a);
    return (m == 0) || (a > m) || (a > P);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // One input cycle: drive at a negedge, let an edge pass, check at the next negedge
  task automatic cycle(int m, int a, bit r, string tag);
    bit expPulse;
    mIn = M_W'(m);
    aIn = A_W'(a);
    rst = r;
    #1;
    check("R8", int'(cfgErr), int'(expErr(m, a)), "cfgErr");
    @(posedge clk);
    @(negedge clk);
    expPulse = 1'b0;
    if (r) begin
      cnt   = 0;
      curN  = ratio(m, a);
      curAe = effA(m, a);
    end else begin
      cnt++;
      if (cnt == curN) begin
        expPulse = 1'b1;
        cnt   = 0;
        curN  = ratio(m, a);
        curAe = effA(m, a);
      end
    end
    check(r ? "R1" : tag, int'(divPulse), int'(expPulse), "divPulse");
    check("R3", int'(modCtl), int'(cnt < curAe * (P + 1)), "modCtl");
  endtask

  task automatic runFor(int m, int a, int n, string tag);
    for (int i = 0; i < n; i++) cycle(m, a, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset state and the first period
    cycle(3, 1, 1'b1, "R1");
    cycle(3, 1, 1'b1, "R1");
    runFor(3, 1, 3 * ratio(3, 1) + 2, "R2");
    // R4: smallest ratio (N = P) keeps the pulses one cycle wide
    cycle(1, 0, 1'b1, "R1");
    runFor(1, 0, 4 * P, "R4");
    // R6: A above M is clamped
    cycle(2, 7, 1'b1, "R1");
    runFor(2, 7, 3 * ratio(2, 7), "R6");
    // R7: M of zero acts as one
    cycle(0, 3, 1'b1, "R1");
    runFor(0, 3, 3 * ratio(0, 3), "R7");
    cycle(0, 0, 1'b1, "R1");
    runFor(0, 0, 3 * P, "R7");
    // R3: full swallow (A = P) and a large M
    cycle(40, 8, 1'b1, "R1");
    runFor(40, 8, 2 * ratio(40, 8), "R3");
    // R5: values changed mid-period wait for the next reload
    cycle(5, 2, 1'b1, "R1");
    runFor(5, 2, 10, "R5");
    runFor(9, 5, 2 * ratio(9, 5) + ratio(5, 2), "R5");
    // R1: reset in the middle of a period restarts it
    runFor(9, 5, 17, "R2");
    cycle(4, 3, 1'b1, "R1");
    runFor(4, 3, 2 * ratio(4, 3), "R1");
    // R8: out-of-range A above P while M is large
    runFor(20, 12, 2 * ratio(20, 12) + 5, "R8");
    // Random mix, values changed at random moments
    for (int k = 0; k < 60; k++) begin
      int m = int'($urandom_range(0, 25));
      int a = int'($urandom_range(0, 15));
      int len = int'($urandom_range(1, 120));
      if ($urandom_range(0, 15) == 0) cycle(m, a, 1'b1, "R1");
      runFor(m, a, len, "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule